// File: doc/BRIEF.md
# Matrix Product Index Schedule Generator

This block drives a chain of multiply-accumulate steps that computes a matrix product kept entirely inside a register file. A single start pulse latches three dimensions and a set of per-operand layout options. Result rows I, result columns J and the shared inner length K need not be powers of two. The block then produces one step per clock. Each step carries three register element indices: one for the left operand A (I by K), one for the right operand B (K by J) and one for the result C (I by J). A valid flag marks each step and a last flag marks the final one.

The step sequence comes from three nested counters with no branching and no unrolling. The inner index k runs fastest, j sits in the middle and i is outermost. Layout options act only on how indices are formed, so the same schedule can drive integer, Galois-field or logical accumulate operations alike. Each operand can be stored transposed, mirrored along its rows or along its columns. Combining these gives 180 and 90 degree rotations. A configuration that needs more than the register file holds is refused with an error flag and no steps.

Top module: `mm_index_sched`

## Requirements
- R1: After reset, valid, last and err are all 0.
- R2: A start seen while no schedule is running latches the dimensions and options. The first step appears in the cycle after that clock edge, and exactly I*J*K steps follow on consecutive cycles with valid high.
- R3: Steps run in nested order: k is innermost, j is in the middle and i is outermost, each counting up from 0.
- R4: With all option bits 0, step (i,j,k) gives idx_a = i*K+k, idx_b = k*J+j and idx_c = i*J+j.
- R5: Option bit 0 (transpose) stores that operand column-major. For an operand with R rows and C columns, element (r,c) then maps to c*R+r instead of r*C+c.
- R6: Option bit 1 replaces the row coordinate r with R-1-r. Option bit 2 replaces the column coordinate c with C-1-c. Both mirrors are applied before the transpose of R5, so bits 1 and 2 together give a 180 degree rotation and bit 0 with one mirror gives a 90 degree rotation.
- R7: last is high on the final step of the product only, and valid is low in the cycle after it.
- R8: A start that arrives while a schedule is running is ignored. The running schedule continues unchanged.
- R9: If any dimension is 0, or I*K, K*J or I*J exceeds 128, the start raises err in the following cycle and no step is issued. The next accepted start with a valid configuration clears err.
- R10: Non-power-of-two shapes such as 5x7, 3x4 and 2x6 run correctly. So do operands of exactly 128 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a schedule with the presented configuration |
| dim_i | input | 8 | Result rows I |
| dim_j | input | 8 | Result columns J |
| dim_k | input | 8 | Inner length K |
| opt_a | input | 3 | Operand A layout: bit0 transpose, bit1 row mirror, bit2 column mirror |
| opt_b | input | 3 | Operand B layout, same encoding |
| opt_c | input | 3 | Result C layout, same encoding |
| valid | output | 1 | A step is presented this cycle |
| last | output | 1 | This step is the final one of the product |
| err | output | 1 | The last accepted configuration was refused |
| idx_a | output | 7 | Register element index for operand A |
| idx_b | output | 7 | Register element index for operand B |
| idx_c | output | 7 | Register element index for the result |

## Verification
The hardest cases to reach are where all three counters wrap at once on an odd-sized shape, and the size boundary at exactly 128 elements against just above it. The stimulus sets up these cases on purpose. It uses mixed prime dimensions, degenerate 1x1x1 and 1x128x1 shapes, and products of 132 and 144 elements. A start that lands mid-run with a different shape checks that a running schedule cannot be disturbed. A reference queue built from the requirements is compared against the ports on every clock.

// File: rtl/mm_sched_pkg.sv
package mm_sched_pkg;

   // per-operand layout options; bit 0 transpose, bit 1 row mirror, bit 2 column mirror
   typedef struct packed {
      logic mir_col;
      logic mir_row;
      logic trn;
   } mm_opt_t;

   localparam int MM_LEVELS = 3;   // k, j, i

endpackage

// File: rtl/mm_cfg_check.sv
module mm_cfg_check
   import mm_sched_pkg::*;
#(
   parameter int DIM_W = 8,
   parameter int REGS  = 128
) (
   input  logic [DIM_W-1:0] dim_i,
   input  logic [DIM_W-1:0] dim_j,
   input  logic [DIM_W-1:0] dim_k,
   output logic             cfg_ok
);
   localparam int PW = 2 * DIM_W;

   logic [2:0] fits;
   logic       nonzero;

   assign nonzero = (dim_i != '0) && (dim_j != '0) && (dim_k != '0);

   for (genvar g = 0; g < 3; g++) begin : g_prod
      logic [DIM_W-1:0] lhs;
      logic [DIM_W-1:0] rhs;
      logic [PW-1:0]    area;
      if (g == 0) begin : g_a
         assign lhs = dim_i;
         assign rhs = dim_k;
      end else if (g == 1) begin : g_b
         assign lhs = dim_k;
         assign rhs = dim_j;
      end else begin : g_c
         assign lhs = dim_i;
         assign rhs = dim_j;
      end
      assign area    = {{DIM_W{1'b0}}, lhs} * {{DIM_W{1'b0}}, rhs};
      assign fits[g] = (area <= PW'(REGS));
   end

   assign cfg_ok = nonzero && (&fits);

endmodule

// File: rtl/mm_loop_nest.sv
module mm_loop_nest
   import mm_sched_pkg::*;
#(
   parameter int DIM_W  = 8,
   parameter int LEVELS = MM_LEVELS
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         advance,
   input  logic [LEVELS-1:0][DIM_W-1:0] bound,
   output logic [LEVELS-1:0][DIM_W-1:0] count,
   output logic                         final_step
);
   logic [LEVELS-1:0] wrap;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic [DIM_W-1:0] cnt_q;
      logic             tick;

      if (l == 0) begin : g_inner
         assign tick = 1'b1;
      end else begin : g_outer
         assign tick = &wrap[l-1:0];
      end

      assign wrap[l]  = (cnt_q == bound[l] - 1'b1);
      assign count[l] = cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clear) begin
            cnt_q <= '0;
         end else if (advance && tick) begin
            cnt_q <= wrap[l] ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assign final_step = &wrap;

endmodule

// File: rtl/mm_operand_map.sv
module mm_operand_map
   import mm_sched_pkg::*;
#(
   parameter int DIM_W = 8,
   parameter int IDX_W = 7
) (
   input  logic [DIM_W-1:0] row,
   input  logic [DIM_W-1:0] col,
   input  logic [DIM_W-1:0] n_rows,
   input  logic [DIM_W-1:0] n_cols,
   input  mm_opt_t          opt,
   output logic [IDX_W-1:0] idx
);
   localparam int PW = 2 * DIM_W;

   logic [DIM_W-1:0] r_eff;
   logic [DIM_W-1:0] c_eff;
   logic [PW-1:0]    major;
   logic [PW-1:0]    linear;

   assign r_eff = opt.mir_row ? (n_rows - 1'b1 - row) : row;
   assign c_eff = opt.mir_col ? (n_cols - 1'b1 - col) : col;

   always_comb begin
      if (opt.trn) begin
         major  = {{DIM_W{1'b0}}, c_eff} * {{DIM_W{1'b0}}, n_rows};
         linear = major + {{DIM_W{1'b0}}, r_eff};
      end else begin
         major  = {{DIM_W{1'b0}}, r_eff} * {{DIM_W{1'b0}}, n_cols};
         linear = major + {{DIM_W{1'b0}}, c_eff};
      end
   end

   assign idx = linear[IDX_W-1:0];

endmodule

// File: rtl/mm_index_sched.sv
module mm_index_sched
   import mm_sched_pkg::*;
#(
   parameter  int DIM_W = 8,
   parameter  int REGS  = 128,
   localparam int IDX_W = $clog2(REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIM_W-1:0] dim_i,
   input  logic [DIM_W-1:0] dim_j,
   input  logic [DIM_W-1:0] dim_k,
   input  logic [2:0]       opt_a,
   input  logic [2:0]       opt_b,
   input  logic [2:0]       opt_c,
   output logic             valid,
   output logic             last,
   output logic             err,
   output logic [IDX_W-1:0] idx_a,
   output logic [IDX_W-1:0] idx_b,
   output logic [IDX_W-1:0] idx_c
);
   localparam int LV = MM_LEVELS;

   if (REGS < 2) begin : g_bad_regs
      $error("mm_index_sched: REGS must be at least 2");
   end
   if ((1 << DIM_W) <= REGS) begin : g_bad_dimw
      $error("mm_index_sched: DIM_W too narrow to express a REGS-long dimension");
   end

   logic                     running_q;
   logic                     err_q;
   logic                     cfg_ok;
   logic                     accept;
   logic                     fin;
   logic [LV-1:0][DIM_W-1:0] bound_q;
   logic [LV-1:0][DIM_W-1:0] count;
   mm_opt_t [2:0]            opt_q;
   logic [2:0][IDX_W-1:0]    idx_w;

   mm_cfg_check #(.DIM_W(DIM_W), .REGS(REGS)) u_check (
      .dim_i  (dim_i),
      .dim_j  (dim_j),
      .dim_k  (dim_k),
      .cfg_ok (cfg_ok)
   );

   assign accept = start && !running_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         err_q     <= 1'b0;
         bound_q   <= '0;
         opt_q     <= '0;
      end else if (accept) begin
         running_q  <= cfg_ok;
         err_q      <= !cfg_ok;
         bound_q[0] <= dim_k;
         bound_q[1] <= dim_j;
         bound_q[2] <= dim_i;
         opt_q[0]   <= mm_opt_t'(opt_a);
         opt_q[1]   <= mm_opt_t'(opt_b);
         opt_q[2]   <= mm_opt_t'(opt_c);
      end else if (running_q && fin) begin
         running_q <= 1'b0;
      end
   end

   mm_loop_nest #(.DIM_W(DIM_W), .LEVELS(LV)) u_nest (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .advance    (running_q),
      .bound      (bound_q),
      .count      (count),
      .final_step (fin)
   );

   // operand 0 = A (i,k), 1 = B (k,j), 2 = C (i,j); count/bound level 0=k, 1=j, 2=i
   for (genvar op = 0; op < 3; op++) begin : g_op
      logic [DIM_W-1:0] r_sel, c_sel, nr_sel, nc_sel;
      if (op == 0) begin : g_a
         assign r_sel  = count[2];
         assign c_sel  = count[0];
         assign nr_sel = bound_q[2];
         assign nc_sel = bound_q[0];
      end else if (op == 1) begin : g_b
         assign r_sel  = count[0];
         assign c_sel  = count[1];
         assign nr_sel = bound_q[0];
         assign nc_sel = bound_q[1];
      end else begin : g_c
         assign r_sel  = count[2];
         assign c_sel  = count[1];
         assign nr_sel = bound_q[2];
         assign nc_sel = bound_q[1];
      end
      mm_operand_map #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_map (
         .row    (r_sel),
         .col    (c_sel),
         .n_rows (nr_sel),
         .n_cols (nc_sel),
         .opt    (opt_q[op]),
         .idx    (idx_w[op])
      );
   end

   assign valid = running_q;
   assign last  = running_q && fin;
   assign err   = err_q;
   assign idx_a = idx_w[0];
   assign idx_b = idx_w[1];
   assign idx_c = idx_w[2];

endmodule

// File: rtl/mm_index_sched_chk.sv
module mm_index_sched_chk #(
   parameter int IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             valid,
   input logic             last,
   input logic             err,
   input logic [IDX_W-1:0] idx_a,
   input logic [IDX_W-1:0] idx_b,
   input logic [IDX_W-1:0] idx_c
);
   assert_last_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> valid);

   assert_drop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && last) |=> !valid);

   assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !last) |=> valid);

   assert_run_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(start));

   assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !valid);

   assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !last && start) |=> (valid && !err));

   logic unused_idx;
   assign unused_idx = ^{idx_a, idx_b, idx_c};

endmodule

bind mm_index_sched mm_index_sched_chk #(.IDX_W(IDX_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .valid (valid),
   .last  (last),
   .err   (err),
   .idx_a (idx_a),
   .idx_b (idx_b),
   .idx_c (idx_c)
);

// File: tb/sim_mm_index_sched.sv
`timescale 1ns/1ps
module sim_mm_index_sched;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] dim_i = '0, dim_j = '0, dim_k = '0;
   logic [2:0] opt_a = '0, opt_b = '0, opt_c = '0;
   logic       valid, last, err;
   logic [6:0] idx_a, idx_b, idx_c;

   int  tests = 0;
   int  fails = 0;
   int  exp_q[$];
   bit  exp_err = 1'b0;
   bit  mon_en = 1'b0;
   bit  done = 1'b0;
   string cur_req = "R2";

   always #2 clk = ~clk;

   mm_index_sched u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dim_i(dim_i), .dim_j(dim_j), .dim_k(dim_k),
      .opt_a(opt_a), .opt_b(opt_b), .opt_c(opt_c),
      .valid(valid), .last(last), .err(err),
      .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c)
   );

   task automatic check(bit ok, string req, int act, int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // element (r,c) of an nr x nc operand under the option bits of R5/R6
   function automatic int eidx(int r, int c, int nr, int nc, int opt);
      int mr, mc;
      mr = opt[1] ? nr - 1 - r : r;
      mc = opt[2] ? nc - 1 - c : c;
      return opt[0] ? mc * nr + mr : mr * nc + mc;
   endfunction

   task automatic run(int di, int dj, int dk, int oa, int ob, int oc, string req);
      bit ok;
      @(negedge clk);
      dim_i = 8'(di); dim_j = 8'(dj); dim_k = 8'(dk);
      opt_a = 3'(oa); opt_b = 3'(ob); opt_c = 3'(oc);
      start = 1'b1;
      cur_req = req;
      ok = di > 0 && dj > 0 && dk > 0 && di*dk <= 128 && dk*dj <= 128 && di*dj <= 128;
      exp_err = !ok;
      if (ok) begin
         for (int i = 0; i < di; i++)
            for (int j = 0; j < dj; j++)
               for (int k = 0; k < dk; k++) begin
                  int e;
                  e = eidx(i, k, di, dk, oa)
                    | (eidx(k, j, dk, dj, ob) << 8)
                    | (eidx(i, j, di, dj, oc) << 16)
                    | (((i == di-1) && (j == dj-1) && (k == dk-1)) ? (1 << 24) : 0);
                  exp_q.push_back(e);
               end
      end
      @(negedge clk);
      start = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // per-clock comparison against the reference queue
   always @(posedge clk) begin
      #1;
      if (mon_en && !done) begin
         int got;
         got = int'(idx_a) | (int'(idx_b) << 8) | (int'(idx_c) << 16) | (int'(last) << 24);
         if (exp_q.size() != 0) begin
            int e;
            e = exp_q.pop_front();
            check(valid === 1'b1 && got == e, cur_req, {valid, got[24:0]}, {1'b1, e[24:0]});
         end else begin
            check(valid === 1'b0 && last === 1'b0, {cur_req, " idle"}, {valid, last}, 0);
         end
         check(err === exp_err, "R9 err flag", int'(err), int'(exp_err));
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(valid === 1'b0, "R1 valid at reset", int'(valid), 0);
      check(last  === 1'b0, "R1 last at reset", int'(last), 0);
      check(err   === 1'b0, "R1 err at reset", int'(err), 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);

      run(2, 3, 4, 0, 0, 0, "R2 R3 R4 plain");
      run(5, 7, 3, 0, 0, 0, "R10 5x7");
      run(3, 4, 2, 0, 0, 0, "R10 3x4");
      run(2, 6, 5, 0, 0, 0, "R10 2x6");
      run(3, 4, 5, 1, 0, 0, "R5 transpose A");
      run(4, 3, 2, 1, 1, 1, "R5 transpose all");
      run(3, 5, 4, 2, 4, 6, "R6 mirrors");
      run(3, 5, 4, 3, 5, 7, "R6 rotations");
      run(1, 1, 1, 0, 0, 0, "R7 single step");

      // R8: second start mid-run with another shape must be ignored
      fork
         run(3, 3, 3, 0, 2, 1, "R8 start while busy");
         begin
            repeat (5) @(negedge clk);
            dim_i = 8'd2; dim_j = 8'd2; dim_k = 8'd2; opt_a = 3'd7;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      join

      run(0, 3, 3, 0, 0, 0, "R9 zero dim");
      run(16, 2, 9, 0, 0, 0, "R9 A oversize");
      run(12, 11, 1, 0, 0, 0, "R9 C oversize");
      run(2, 2, 2, 0, 0, 0, "R9 err cleared");
      run(1, 128, 1, 0, 1, 4, "R10 128 elements");
      run(128, 1, 1, 2, 0, 1, "R10 128 rows");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule